// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block models a byte-wide serial EEPROM that answers as a target on a two-wire bus. A fast system clock samples the bus clock and data lines. The block pulls the data line low through an open-drain style output and otherwise lets it float high. The storage array is 256 or 512 bytes, chosen by a parameter. The page is 8 bytes for the small array and 16 bytes for the large one.

A controller selects the device with a device word. The word carries a fixed 1010 prefix, address bits that are checked against hard-wired pins, and a direction bit. A write then sends one word-address byte and any number of data bytes. These bytes collect in a page buffer and reach the array only when the controller sends a stop. A programmable busy period follows each committed write. During it the device does not answer, so the controller can poll for completion.

Reads can start at the address the device holds from the last access, or at a fresh address loaded by a dummy write followed by a repeated start. A read continues byte after byte for as long as the controller acknowledges. A write-protect input blocks all array updates.

Top module: `twowire_eeprom`

## Requirements
- R1: A start is SDA falling while SCL is high. The device word that follows is read MSB first. The device answers only if bits 7:4 are 1010 and the pin-address bits match, and bit 0 selects read (1) or write (0). For the 256-byte array, bits 3:1 must equal pins [2:0]. On a mismatch the device stays silent until the next start.
- R2: For the 512-byte array, only word bits 3:2 are compared, against pins [2:1]. Word bit 1 becomes address bit 8 of the word address loaded by a write, and pin [0] is ignored.
- R3: The device pulls SDA low during the ninth SCL clock after every byte it receives (device word, word address, data), provided that byte is accepted.
- R4: In a write, the first byte after the device word sets the address and each later byte is data for successive locations. The data is stored in the array after the stop.
- R5: Within a write, only the low 3 bits (256-byte array) or low 4 bits (512-byte array) of the address advance. A write longer than one page wraps to the start of the same page, and the later bytes overwrite the earlier ones.
- R6: After a stop commits data, the device gives no acknowledge to its device word for BUSY_CYCLES system clocks. After that period it acknowledges again.
- R7: Between transfers the device keeps the address of the last byte accessed, plus one. A read that is not preceded by an address byte starts at that location.
- R8: During a read, every acknowledge from the controller makes the device send the next byte. The read address wraps from the last array byte to byte 0. A missing acknowledge ends the read, and the device lets SDA float.
- R9: With wp_i high, data bytes are still acknowledged, but the array does not change and no busy period starts.
- R10: Only complete data bytes are stored. A stop during a byte discards that byte. A transfer with no complete data byte writes nothing and starts no busy period. A repeated start drops any data collected but not yet committed.
- R11: After reset the array and the address counter are zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| addr_pins_i | input | 3 | Hard-wired device address pins |
| wp_i | input | 1 | Write protect for the whole array |

## Verification
Bus inputs pass through two synchronizer stages and one edge-detect stage. The device therefore changes sda_pull_o three system clocks after the SCL edge that calls for it. The bench reads SDA half-way through each SCL high phase, at least six clocks after that change. Array contents are checked only by reading them back over the bus after the stop and after the busy period has ended. Busy-period results are judged by polling: the first poll right after a stop must go unanswered, and a later poll must be acknowledged within a bounded number of attempts.

// File: rtl/twowire_eeprom.sv
module twowire_eeprom #(
  parameter int MEM_BYTES   = 256,
  parameter int BUSY_CYCLES = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] addr_pins_i,
  input  logic       wp_i
);
  localparam bit WIDE = (MEM_BYTES > 256);
  localparam int AW   = $clog2(MEM_BYTES);
  localparam int PAGE = WIDE ? 16 : 8;
  localparam int PB   = $clog2(PAGE);
  localparam int BW   = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_ADDR, S_ADDR_ACK, S_WR, S_WR_ACK, S_RD, S_RD_ACK
  } st_t;

  st_t             state;
  logic [2:0]      scl_q, sda_q;
  logic [7:0]      sh, tx;
  logic [3:0]      cnt;
  logic [AW-1:0]   ptr;
  logic            rw, blk, mack;
  logic [7:0]      pbuf [PAGE];
  logic [PAGE-1:0] pmask;
  logic [BW-1:0]   bcnt;
  logic [7:0]      mem [MEM_BYTES];
  logic            id_ok;

  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire bus_start = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
  wire bus_stop  = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];
  wire busy = (bcnt != '0);
  wire [PB-1:0] off = ptr[PB-1:0];
  wire in_write = (state == S_WR) || (state == S_WR_ACK);

  always_comb begin
    if (WIDE) id_ok = (sh[7:4] == 4'b1010) && (sh[3:2] == addr_pins_i[2:1]);
    else      id_ok = (sh[7:4] == 4'b1010) && (sh[3:1] == addr_pins_i);
  end

  assign sda_pull_o = (state == S_DEV_ACK) || (state == S_ADDR_ACK) ||
                      (state == S_WR_ACK) || ((state == S_RD) && !tx[7]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sh    <= '0;
      tx    <= '0;
      cnt   <= '0;
      ptr   <= '0;
      rw    <= 1'b0;
      blk   <= 1'b0;
      mack  <= 1'b0;
      pmask <= '0;
      bcnt  <= '0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
    end else begin
      if (busy) bcnt <= bcnt - BW'(1);
      if (bus_stop) begin
        if (in_write && (pmask != '0) && !wp_i) begin
          for (int i = 0; i < PAGE; i++)
            if (pmask[i]) mem[{ptr[AW-1:PB], PB'(i)}] <= pbuf[i];
          bcnt <= BW'(BUSY_CYCLES);
        end
        pmask <= '0;
        state <= S_IDLE;
      end else if (bus_start) begin
        pmask <= '0;
        cnt   <= '0;
        state <= S_DEV;
      end else begin
        case (state)
          S_DEV, S_ADDR, S_WR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_q[1]};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (state == S_DEV) begin
                if (id_ok && !busy) begin
                  rw    <= sh[0];
                  blk   <= sh[1];
                  state <= S_DEV_ACK;
                end else begin
                  state <= S_IDLE;
                end
              end else if (state == S_ADDR) begin
                ptr   <= AW'({blk, sh});
                state <= S_ADDR_ACK;
              end else begin
                pbuf[off]      <= sh;
                pmask[off]     <= 1'b1;
                ptr[PB-1:0]    <= off + PB'(1);
                state          <= S_WR_ACK;
              end
            end
          end
          S_DEV_ACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx    <= mem[ptr];
              ptr   <= ptr + AW'(1);
              state <= S_RD;
            end else begin
              state <= S_ADDR;
            end
          end
          S_ADDR_ACK, S_WR_ACK: if (scl_fall) begin
            cnt   <= '0;
            state <= S_WR;
          end
          S_RD: if (scl_fall) begin
            if (cnt == 4'd7) state <= S_RD_ACK;
            else begin
              tx  <= {tx[6:0], 1'b0};
              cnt <= cnt + 4'd1;
            end
          end
          S_RD_ACK: begin
            if (scl_rise) mack <= ~sda_q[1];
            if (scl_fall) begin
              cnt <= '0;
              if (mack) begin
                tx    <= mem[ptr];
                ptr   <= ptr + AW'(1);
                state <= S_RD;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_page_row_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_write && ($past(state) == S_WR || $past(state) == S_WR_ACK)) |-> $stable(ptr[AW-1:PB]));

  p_busy_counts_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (bcnt == $past(bcnt) - BW'(1)));

  p_no_answer_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state == S_DEV) |=> (state != S_DEV_ACK));

  p_protected_no_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp_i));

  p_release_for_master_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD_ACK) |-> !sda_pull_o);
endmodule

// File: tb/test_twowire_eeprom.sv
module test_twowire_eeprom;
  localparam int BUSY = 300;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic wp_a = 1'b0, wp_b = 1'b0;
  logic pull_a, pull_b;
  wire  sda_bus = m_sda & ~pull_a & ~pull_b;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] emA [256];
  logic [7:0] emB [512];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [300];

  always #10 clk = ~clk;

  twowire_eeprom #(.MEM_BYTES(256), .BUSY_CYCLES(BUSY)) i_twowire_eeprom (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_pull_o(pull_a),
    .addr_pins_i(3'b000), .wp_i(wp_a));

  twowire_eeprom #(.MEM_BYTES(512), .BUSY_CYCLES(BUSY)) i_twowire_eeprom_wide (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_pull_o(pull_b),
    .addr_pins_i(3'b011), .wp_i(wp_b));

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string req);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda = 1'b1; hw(); scl = 1'b1; hw(); m_sda = 1'b0; hw(); scl = 1'b0; hw();
  endtask

  task automatic bstop();
    m_sda = 1'b0; hw(); scl = 1'b1; hw(); m_sda = 1'b1; hw();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; hw(); scl = 1'b1; hw(); scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_sda = 1'b1; hw(); scl = 1'b1;
    repeat (H/2) @(negedge clk);
    ack = ~sda_bus;
    repeat (H - H/2) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(); scl = 1'b1;
      repeat (H/2) @(negedge clk);
      b[i] = sda_bus;
      repeat (H - H/2) @(negedge clk);
      scl = 1'b0;
    end
    m_sda = ~give_ack; hw(); scl = 1'b1; hw(); scl = 1'b0;
  endtask

  task automatic wr(input logic [7:0] dw, input logic [7:0] a, input int n, output bit ok);
    bit ak;
    bstart(); send_byte(dw, ak); ok = ak;
    send_byte(a, ak); ok &= ak;
    for (int k = 0; k < n; k++) begin send_byte(wbuf[k], ak); ok &= ak; end
    bstop();
  endtask

  task automatic rd_rand(input logic [7:0] dw, input logic [7:0] a, input int n);
    bit ak;
    bstart(); send_byte(dw, ak); send_byte(a, ak);
    bstart(); send_byte(dw | 8'h01, ak);
    for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
    bstop();
  endtask

  task automatic rd_cur(input logic [7:0] dw, input int n);
    bit ak;
    bstart(); send_byte(dw | 8'h01, ak);
    for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
    bstop();
  endtask

  task automatic poll(input logic [7:0] dw, output bit ak);
    bstart(); send_byte(dw, ak); bstop();
  endtask

  task automatic wait_ready(input logic [7:0] dw, output int tries);
    bit ak = 0;
    tries = 0;
    while (!ak && tries < 20) begin poll(dw, ak); tries++; end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ 8'h5A);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit ok, ak;
    int tries;
    for (int i = 0; i < 256; i++) emA[i] = 8'h00;
    for (int i = 0; i < 512; i++) emB[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk(16'(sda_bus), 16'h1, "R11 released after reset");
    rd_cur(8'hA0, 1);
    chk(16'(rbuf[0]), 16'h00, "R11 array and counter zero");

    poll(8'hB0, ak); chk(16'(ak), 16'h0, "R1 bad prefix no ack");
    poll(8'hA2, ak); chk(16'(ak), 16'h0, "R1 pin mismatch no ack");
    poll(8'hA0, ak); chk(16'(ak), 16'h1, "R1 matching word ack");

    for (int pg = 0; pg < 32; pg++) begin
      for (int k = 0; k < 8; k++) begin wbuf[k] = pat(pg * 8 + k); emA[pg * 8 + k] = wbuf[k]; end
      wr(8'hA0, 8'(pg * 8), 8, ok);
      chk(16'(ok), 16'h1, "R3 every byte acknowledged");
      wait_ready(8'hA0, tries);
    end
    rd_rand(8'hA0, 8'h00, 258);
    for (int i = 0; i < 258; i++) chk(16'(rbuf[i]), 16'(emA[i % 256]), "R4 R8 sweep readback and wrap");
    rd_cur(8'hA0, 1);
    chk(16'(rbuf[0]), 16'(emA[2]), "R7 current read after wrap");

    for (int k = 0; k < 10; k++) begin
      wbuf[k] = 8'(8'hC0 + k);
      emA[8'h10 | ((3 + k) & 7)] = wbuf[k];
    end
    wr(8'hA0, 8'h13, 10, ok);
    poll(8'hA0, ak); chk(16'(ak), 16'h0, "R6 first poll unanswered");
    wait_ready(8'hA0, tries);
    chk(16'(tries > 1 && tries < 10), 16'h1, "R6 answers again after busy");
    rd_cur(8'hA0, 1);
    chk(16'(rbuf[0]), 16'(emA[8'h15]), "R7 counter after page wrap");
    rd_rand(8'hA0, 8'h10, 8);
    for (int i = 0; i < 8; i++) chk(16'(rbuf[i]), 16'(emA[8'h10 + i]), "R5 page wrap overwrite");

    wp_a = 1'b1;
    wbuf[0] = ~emA[8'h40];
    wr(8'hA0, 8'h40, 1, ok);
    chk(16'(ok), 16'h1, "R9 protected bytes still acked");
    poll(8'hA0, ak); chk(16'(ak), 16'h1, "R9 no busy when protected");
    wp_a = 1'b0;
    rd_rand(8'hA0, 8'h40, 1);
    chk(16'(rbuf[0]), 16'(emA[8'h40]), "R9 array unchanged");

    bstart(); send_byte(8'hA0, ak); send_byte(8'h50, ak);
    send_byte(8'h3C, ak); send_bits(8'h00, 5); bstop();
    emA[8'h50] = 8'h3C;
    wait_ready(8'hA0, tries);
    rd_rand(8'hA0, 8'h50, 2);
    chk(16'(rbuf[0]), 16'(emA[8'h50]), "R10 full byte stored");
    chk(16'(rbuf[1]), 16'(emA[8'h51]), "R10 partial byte dropped");
    bstart(); send_byte(8'hA0, ak); send_byte(8'h60, ak); send_bits(8'hFF, 4); bstop();
    poll(8'hA0, ak); chk(16'(ak), 16'h1, "R10 no data no busy");
    bstart(); send_byte(8'hA0, ak); send_byte(8'h61, ak); send_byte(8'h99, ak);
    bstart(); send_byte(8'hA1, ak); recv_byte(1'b0, rbuf[0]); bstop();
    poll(8'hA0, ak); chk(16'(ak), 16'h1, "R10 repeated start drops data");
    rd_rand(8'hA0, 8'h61, 1);
    chk(16'(rbuf[0]), 16'(emA[8'h61]), "R10 location untouched");

    for (int k = 0; k < 18; k++) begin
      wbuf[k] = 8'(k * 29 + 3);
      emB[9'h1F0 | ((k) & 15)] = wbuf[k];
    end
    wr(8'hA6, 8'hF0, 18, ok);
    chk(16'(ok), 16'h1, "R2 wide device acks with pin0 ignored");
    wait_ready(8'hA6, tries);
    rd_rand(8'hA6, 8'hF0, 16);
    for (int i = 0; i < 16; i++) chk(16'(rbuf[i]), 16'(emB[9'h1F0 + i]), "R2 R5 wide page wrap");
    rd_rand(8'hA4, 8'hF0, 1);
    chk(16'(rbuf[0]), 16'(emB[9'h0F0]), "R2 page bit is address bit 8");
    rd_rand(8'hA6, 8'hFF, 2);
    chk(16'(rbuf[0]), 16'(emB[9'h1FF]), "R8 wide last byte");
    chk(16'(rbuf[1]), 16'(emB[0]), "R8 wide wrap to zero");
    chk(16'(sda_bus), 16'h1, "R8 line released after read");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule